// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Receiver

This block is the receiving end of a bit-serial configuration port. An external source supplies a configuration clock and one data bit per rising edge. The block first takes in a fixed, per-device number of bits for itself. It packs them into bytes for a configuration-memory writer and strobes each full byte. After its own quota is complete, it raises a done flag. From then on it forwards every later bit to its serial output, which lets several devices in a chain be loaded from a single bitstream.

The port runs only while the mode pins select slave-serial operation, which means the two low mode bits are both high. It does not begin taking bits until the shared init line has been seen high. An active-low program input restarts the whole sequence.

Top module: `cfg_serial_rx`

## Requirements
- R1: With `prog_n` low at a rising `cfg_clk` edge, the block returns to waiting for init. After that edge `done`, `sdo` and `byte_wr` are 0 and `byte_data` is 0. Once `prog_n` goes high again, a full `OWN_BITS` bits must be taken before `done` returns.
- R2: The port runs only when `mode_sel[1:0]` is `2'b11`, so codes 111 and 011 both run and `mode_sel[2]` is ignored. On an edge with any other code, no bit is counted or captured, `byte_wr` is 0 after that edge, and `sdo` is driven 0.
- R3: After program, no bit is taken until `init_ok` is sampled high at some edge. The first bit taken is the one sampled at the following edge. A later fall of `init_ok` does not stop loading.
- R4: Bits are packed first-received-first, so the first bit of a byte ends up in `byte_data[7]`. After the edge that captures the 8th bit of a byte, `byte_wr` is 1 for exactly one cycle and `byte_data` holds that byte.
- R5: `done` goes to 1 after the edge that captures bit number `OWN_BITS`. It stays at 1 until `prog_n` is sampled low.
- R6: While `done` is 0, `sdo` is 0. While `done` is 1 and the mode runs, `sdo` after each rising edge equals the `sdi` sampled at that edge.
- R7: If `OWN_BITS` is not a multiple of 8, the trailing partial byte is dropped. No `byte_wr` occurs after the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | External configuration clock; all state changes on its rising edge |
| prog_n | input | 1 | Active-low program, synchronous restart |
| mode_sel | input | 3 | Mode pins; runs when bits [1:0] are 11 |
| init_ok | input | 1 | Chain-wide init released (high) |
| sdi | input | 1 | Serial configuration data in |
| sdo | output | 1 | Serial data forwarded to the next chained device |
| done | output | 1 | Own configuration bits complete |
| byte_wr | output | 1 | One-cycle strobe: `byte_data` holds a full byte |
| byte_data | output | 8 | Last assembled configuration byte |

## Verification
A bit counter that is off by one shows up at the ports as `done` rising a cycle early or late. It also shows up as the first forwarded bit being lost, or as an extra own bit leaking onto `sdo`. All of these appear within one clock of the expected completion edge. A shift register or byte-position error shows up as a wrong `byte_data` value or a misplaced `byte_wr` on the very first byte. A broken mode or init gate shifts every later strobe and the completion edge, so the per-cycle comparison against the reference model catches it within a few cycles of the stimulus.

// File: rtl/cfg_rx_pkg.sv
// Shared types for the serial configuration receiver.
package cfg_rx_pkg;
    // Receiver phases: wait for init release, load own bits, forward chain bits
    typedef enum logic [1:0] {
        CR_WAIT = 2'd0,
        CR_LOAD = 2'd1,
        CR_PASS = 2'd2
    } cr_state_t;
endpackage

// File: rtl/cfg_bit_counter.sv
// Counts the bits this device keeps for itself.
// Assumes: step is high only for a captured own bit; rst_n is synchronous.
// last is high in the cycle whose step captures bit number TOTAL.
module cfg_bit_counter #(
    parameter int TOTAL = 3430400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt;

    // Advance once per captured own bit; clear on program
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= cnt + CW'(1);
    end

    assign last = step && (cnt == CW'(TOTAL - 1));
endmodule

// File: rtl/cfg_byte_assembler.sv
// Packs captured bits into bytes, first bit into the MSB, and pulses a
// one-cycle write strobe with each completed byte.
// Assumes: shift_en is high only for captured own bits; clear drops a partial byte.
module cfg_byte_assembler #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              byte_wr,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int PW = $clog2(BYTE_W);

    logic [PW-1:0]     pos;
    logic [BYTE_W-2:0] partial;

    // Track bit position inside the current byte and collect its bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= '0;
            partial <= '0;
        end else if (shift_en) begin
            partial <= {partial[BYTE_W-3:0], bit_in};
            pos     <= (pos == PW'(BYTE_W - 1)) ? '0 : pos + PW'(1);
        end
    end

    // Publish a full byte with a single-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_wr   <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_wr <= shift_en && (pos == PW'(BYTE_W - 1));
            if (shift_en && (pos == PW'(BYTE_W - 1)))
                byte_data <= {partial, bit_in};
        end
    end
endmodule

// File: rtl/cfg_chain_forward.sv
// Registers chain data onto the serial output on the rising edge.
// Assumes: fwd_en is high only after own bits are complete and the mode runs;
// otherwise the output is held low.
module cfg_chain_forward (
    input  logic clk,
    input  logic rst_n,
    input  logic fwd_en,
    input  logic bit_in,
    output logic sdo
);
    // Pass the sampled bit downstream, or hold low
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdo <= 1'b0;
        else
            sdo <= fwd_en ? bit_in : 1'b0;
    end
endmodule

// File: rtl/cfg_serial_rx.sv
// Slave-side serial configuration receiver with daisy-chain forwarding.
// Waits for init release, takes OWN_BITS bits into bytes, then raises done
// and forwards all further bits on sdo. Runs only for mode codes x11.
// Assumes: cfg_clk is the free external clock; prog_n acts synchronously.
module cfg_serial_rx
    import cfg_rx_pkg::*;
#(
    parameter int OWN_BITS = 3430400,
    parameter int BYTE_W   = 8
) (
    input  logic              cfg_clk,
    input  logic              prog_n,
    input  logic [2:0]        mode_sel,
    input  logic              init_ok,
    input  logic              sdi,
    output logic              sdo,
    output logic              done,
    output logic              byte_wr,
    output logic [BYTE_W-1:0] byte_data
);
    cr_state_t state;
    logic      mode_run;
    logic      load_step;
    logic      load_last;

    assign mode_run  = (mode_sel[1:0] == 2'b11);
    assign load_step = (state == CR_LOAD) && mode_run;
    assign done      = (state == CR_PASS);

    // Phase sequencing: init gate, own-bit loading, then chain pass-through
    always_ff @(posedge cfg_clk) begin
        if (!prog_n)
            state <= CR_WAIT;
        else begin
            case (state)
                CR_WAIT: if (init_ok)   state <= CR_LOAD;
                CR_LOAD: if (load_last) state <= CR_PASS;
                default: state <= CR_PASS;
            endcase
        end
    end

    cfg_bit_counter #(.TOTAL(OWN_BITS)) u_count (
        .clk   (cfg_clk),
        .rst_n (prog_n),
        .step  (load_step),
        .last  (load_last)
    );

    cfg_byte_assembler #(.BYTE_W(BYTE_W)) u_pack (
        .clk       (cfg_clk),
        .rst_n     (prog_n),
        .shift_en  (load_step),
        .bit_in    (sdi),
        .byte_wr   (byte_wr),
        .byte_data (byte_data)
    );

    cfg_chain_forward u_fwd (
        .clk    (cfg_clk),
        .rst_n  (prog_n),
        .fwd_en (done && mode_run),
        .bit_in (sdi),
        .sdo    (sdo)
    );
endmodule

// File: rtl/cfg_rx_chk.sv
// Port-level protocol checks for cfg_serial_rx, attached by bind.
module cfg_rx_chk (
    input logic       cfg_clk,
    input logic       prog_n,
    input logic [2:0] mode_sel,
    input logic       sdi,
    input logic       sdo,
    input logic       done,
    input logic       byte_wr
);
    // R1
    reset_clears_chk: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        $rose(prog_n) |-> (!done && !sdo && !byte_wr));

    // R2
    idle_mode_chk: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (mode_sel[1:0] != 2'b11) |=> (!byte_wr && !sdo));

    // R4
    strobe_single_chk: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        byte_wr |=> !byte_wr);

    // R5
    done_sticky_chk: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        done |=> done);

    // R6
    quiet_while_loading_chk: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        !done |-> !sdo);

    // R6
    forward_bit_chk: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (done && mode_sel[1:0] == 2'b11) |=> (sdo == $past(sdi)));

    // R7
    no_strobe_after_done_chk: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (done && $past(done)) |-> !byte_wr);
endmodule

bind cfg_serial_rx cfg_rx_chk u_chk (
    .cfg_clk  (cfg_clk),
    .prog_n   (prog_n),
    .mode_sel (mode_sel),
    .sdi      (sdi),
    .sdo      (sdo),
    .done     (done),
    .byte_wr  (byte_wr)
);

// File: tb/cfg_serial_rx_test.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module cfg_serial_rx_test;
    localparam int N = 20;

    logic       clk = 1'b0;
    logic       prog_n = 1'b0;
    logic [2:0] mode_sel = 3'b111;
    logic       init_ok = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo, done, byte_wr;
    logic [7:0] byte_data;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit finished = 1'b0;

    // model state
    int m_st = 0, m_cnt = 0, m_pos = 0, m_sh = 0, m_data = 0;
    bit m_done = 0, m_sdo = 0, m_wr = 0;

    always #4 clk = ~clk;

    cfg_serial_rx #(.OWN_BITS(N)) uut (
        .cfg_clk(clk), .prog_n(prog_n), .mode_sel(mode_sel), .init_ok(init_ok),
        .sdi(sdi), .sdo(sdo), .done(done), .byte_wr(byte_wr), .byte_data(byte_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced at every rising edge
    always @(posedge clk) begin
        if (!prog_n) begin
            m_st = 0; m_cnt = 0; m_pos = 0; m_sh = 0; m_data = 0;
            m_done = 0; m_sdo = 0; m_wr = 0;
        end else begin
            m_wr = 0;
            case (m_st)
                0: begin m_sdo = 0; if (init_ok) m_st = 1; end
                1: begin
                    m_sdo = 0;
                    if (mode_sel[1:0] == 2'b11) begin
                        m_sh = ((m_sh << 1) | int'(sdi)) & 255;
                        m_pos++;
                        if (m_pos == 8) begin m_wr = 1; m_data = m_sh; m_pos = 0; end
                        m_cnt++;
                        if (m_cnt == N) begin m_st = 2; m_done = 1; m_pos = 0; end
                    end
                end
                default: m_sdo = (mode_sel[1:0] == 2'b11) ? sdi : 1'b0;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            check("R5 done", int'(done), int'(m_done));
            check("R6 sdo", int'(sdo), int'(m_sdo));
            check("R4 byte_wr", int'(byte_wr), int'(m_wr));
            if (m_wr) check("R4 byte_data", int'(byte_data), m_data);
            if (byte_wr) strobes++;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            sdi = 1'($urandom);
        end
    endtask

    initial begin
        cycles(3);
        @(negedge clk); #2;
        check("R1 done after reset", int'(done), 0);
        check("R1 sdo after reset", int'(sdo), 0);
        check("R1 byte_wr after reset", int'(byte_wr), 0);
        prog_n = 1'b1;
        // init held low: nothing loads (R3)
        cycles(N + 5);
        check("R3 no load before init", int'(done), 0);
        check("R3 no strobe before init", strobes, 0);
        init_ok = 1'b1;
        cycles(5);
        init_ok = 1'b0;              // later fall ignored (R3)
        cycles(N - 3);
        @(negedge clk); #2;
        check("R5 done after own bits", int'(done), 1);
        check("R7 two full bytes, partial dropped", strobes, 2);
        cycles(12);                  // pass-through (R6)
        mode_sel = 3'b010;
        cycles(6);                   // idle mode while passing (R2)
        mode_sel = 3'b011;
        cycles(6);
        check("R7 no strobes during pass", strobes, 2);
        // restart (R1)
        prog_n = 1'b0;
        cycles(1);
        prog_n = 1'b1;
        init_ok = 1'b1;
        cycles(11);
        mode_sel = 3'b100;           // idle mode mid-load (R2)
        cycles(15);
        @(negedge clk); #2;
        check("R2 load frozen in idle mode", int'(done), 0);
        mode_sel = 3'b111;
        cycles(N - 9);
        @(negedge clk); #2;
        check("R1 full reload before done", int'(done), 1);
        check("R7 strobes after reload", strobes, 4);
        cycles(10);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule